// File: doc/BRIEF.md
# Vector Element Integer, Logical and Shift ALU

This block runs one 32-bit integer, Boolean or shift operation over a vector of 64-bit register elements, taking one element pair per cycle. A run is launched by a single `start` pulse carrying the operation code, the vector length and the choice of first operand. The first operand comes either from a scalar captured at launch and broadcast to every element, or from the low half of each incoming Va element. The second operand is always the incoming Vb element. A neighbouring sequencer streams the element pairs in with `in_valid`, and gaps in that stream are allowed. Each accepted pair produces one registered result element together with its index.

Only bits [31:0] of each element take part in the computation. Boolean operations carry the upper half of Vb through to the result. Add, subtract, multiply and shift results have an upper half of zero. A sticky flag records signed 32-bit overflow from add, subtract and multiply. The flag is cleared when the next run is launched.

A three-state controller sequences each run:
- IDLE waits for `start`. It moves to RUN when the clamped length is non-zero, and to FINISH when the length is zero.
- RUN accepts one element pair on every cycle with `in_valid`. It moves to FINISH when it accepts the last element.
- FINISH raises `done` for one cycle and then returns to IDLE.

Top module: `vec_elem_alu`

## Requirements
- R1: After reset `busy`, `out_valid`, `done` and `ovf_flag` are all 0.
- R2: The operation codes are 0 add, 1 subtract, 2 multiply, 3 bit-clear, 4 bit-set, 5 exclusive-or, 6 shift left and 7 shift right. Add and subtract work on 32 bits with wrap-around, subtract computes first operand minus Vb[31:0], and the result bits [63:32] are 0.
- R3: `ovf_flag` is cleared by an accepted `start`. It is set after any add, subtract or multiply element whose true signed result does not fit in 32 bits, and it then holds until the next accepted `start`.
- R4: Multiply forms the signed 64-bit product of the two 32-bit operands and returns its low 32 bits, with result bits [63:32] equal to 0.
- R5: Bit-clear returns Vb AND NOT operand, bit-set returns Vb OR operand, and exclusive-or returns Vb XOR operand, all on bits [31:0]. Result bits [63:32] equal Vb bits [63:32].
- R6: Shift left and shift right move Vb[31:0] by the count in operand bits [4:0] only, filling the vacated bits with zeros. Result bits [63:32] are 0.
- R7: When `src_scalar` is 1 at launch, the scalar captured at launch is the first operand for every element. When it is 0, Va[31:0] is the first operand, and Va[63:32] is ignored in both cases.
- R8: A run yields exactly min(`vec_len`, MAX_VL) results, indexed 0 upward in order. `done` is high for one cycle, in the same cycle as the last result. A length of 0 gives `done` with no result.
- R9: A result appears only in the cycle after an element was accepted, so `in_valid` low produces no result. A `start` while a run is in progress is ignored, including its operation code and operands.
- R10: Boolean and shift operations never set `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a run (accepted only when idle) |
| op_code | input | 3 | Operation code, captured at launch |
| src_scalar | input | 1 | 1: broadcast scalar first operand; 0: Va |
| scalar_opnd | input | 32 | Scalar first operand, captured at launch |
| vec_len | input | 7 | Element count, clamped to MAX_VL |
| in_valid | input | 1 | Element pair present on va_elem/vb_elem |
| va_elem | input | 64 | First-operand vector element |
| vb_elem | input | 64 | Second-operand vector element |
| busy | output | 1 | Run in progress, elements accepted |
| out_valid | output | 1 | Result element present |
| out_index | output | 7 | Index of the present result |
| vc_elem | output | 64 | Result element |
| done | output | 1 | One-cycle end-of-run pulse |
| ovf_flag | output | 1 | Sticky signed overflow flag |

## Verification
Two events can land in the same cycle: the last result of a run appears on `vc_elem` at the moment `done` pulses, and a signed overflow on that last element becomes visible on `ovf_flag`. The bench provokes both by placing the overflowing operand pair last in a run, and in other runs with stalls between elements. The monitor judges each result item by its "last" mark, requiring `done` in exactly that cycle and comparing `ovf_flag` there with the overflow predicted over the whole run. A zero-length run checks `done` alone, and a run that follows an overflowing run checks that the flag was cleared at launch.

// File: rtl/vec_elem_alu_pkg.sv
package vec_elem_alu_pkg;

    typedef enum logic [2:0] {
        VOP_ADD = 3'd0,
        VOP_SUB = 3'd1,
        VOP_MUL = 3'd2,
        VOP_BIC = 3'd3,
        VOP_BIS = 3'd4,
        VOP_XOR = 3'd5,
        VOP_SLL = 3'd6,
        VOP_SRL = 3'd7
    } vop_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RUN    = 2'd1,
        S_FINISH = 2'd2
    } run_state_e;

    function automatic logic vop_is_arith(input vop_e op);
        return (op == VOP_ADD) || (op == VOP_SUB) || (op == VOP_MUL);
    endfunction

    function automatic logic vop_is_bool(input vop_e op);
        return (op == VOP_BIC) || (op == VOP_BIS) || (op == VOP_XOR);
    endfunction

endpackage

// File: rtl/vec_run_ctrl.sv
module vec_run_ctrl
    import vec_elem_alu_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int LEN_W  = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] vec_len,
    input  logic             in_valid,
    output logic             launch,
    output logic             accept,
    output logic [LEN_W-1:0] elem_idx,
    output logic             busy,
    output logic             done
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_VL);

    run_state_e       state_q, state_d;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_clamped;
    logic             last_accept;

    always_comb begin
        len_clamped = (vec_len > MAX_LEN) ? MAX_LEN : vec_len;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = (len_clamped == '0) ? S_FINISH : S_RUN;
            end
            S_RUN: begin
                if (last_accept) state_d = S_FINISH;
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy        = (state_q == S_RUN);
        done        = (state_q == S_FINISH);
        launch      = (state_q == S_IDLE) && start;
        accept      = busy && in_valid;
        last_accept = accept && (elem_idx == len_q - LEN_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q    <= '0;
            elem_idx <= '0;
        end else if (launch) begin
            len_q    <= len_clamped;
            elem_idx <= '0;
        end else if (accept) begin
            elem_idx <= elem_idx + LEN_W'(1);
        end
    end

endmodule

// File: rtl/vec_arith_unit.sv
module vec_arith_unit
    import vec_elem_alu_pkg::*;
#(
    parameter int OPND_W = 32
) (
    input  vop_e              op,
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    output logic [OPND_W-1:0] result,
    output logic              overflow
);
    localparam int PROD_W = 2 * OPND_W;

    logic [OPND_W-1:0] sum, diff;
    logic [PROD_W-1:0] prod;
    logic              sum_ovf, diff_ovf, prod_ovf;

    always_comb begin
        sum      = opnd_a + opnd_b;
        diff     = opnd_a - opnd_b;
        prod     = PROD_W'($signed(opnd_a) * $signed(opnd_b));
        sum_ovf  = (opnd_a[OPND_W-1] == opnd_b[OPND_W-1]) &&
                   (sum[OPND_W-1] != opnd_a[OPND_W-1]);
        diff_ovf = (opnd_a[OPND_W-1] != opnd_b[OPND_W-1]) &&
                   (diff[OPND_W-1] != opnd_a[OPND_W-1]);
        // the product fits when its upper half is all copies of bit OPND_W-1
        prod_ovf = (prod[PROD_W-1:OPND_W-1] != '0) &&
                   (prod[PROD_W-1:OPND_W-1] != '1);
        unique case (op)
            VOP_SUB: begin result = diff;              overflow = diff_ovf; end
            VOP_MUL: begin result = prod[OPND_W-1:0];  overflow = prod_ovf; end
            default: begin result = sum;               overflow = sum_ovf;  end
        endcase
    end

endmodule

// File: rtl/vec_bool_unit.sv
module vec_bool_unit
    import vec_elem_alu_pkg::*;
#(
    parameter int OPND_W = 32,
    parameter int ELEM_W = 64
) (
    input  vop_e              op,
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [ELEM_W-1:0] vb,
    output logic [ELEM_W-1:0] result
);
    logic [OPND_W-1:0] low;

    always_comb begin
        unique case (op)
            VOP_BIC: low = vb[OPND_W-1:0] & ~opnd_a;
            VOP_BIS: low = vb[OPND_W-1:0] | opnd_a;
            default: low = vb[OPND_W-1:0] ^ opnd_a;
        endcase
        result = {vb[ELEM_W-1:OPND_W], low};
    end

endmodule

// File: rtl/vec_shift_unit.sv
module vec_shift_unit #(
    parameter int OPND_W = 32,
    parameter int CNT_W  = $clog2(OPND_W)
) (
    input  logic              shift_right,
    input  logic [OPND_W-1:0] count_src,
    input  logic [OPND_W-1:0] value,
    output logic [OPND_W-1:0] result
);
    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt    = count_src[CNT_W-1:0];
        result = shift_right ? (value >> cnt) : (value << cnt);
    end

endmodule

// File: rtl/vec_elem_alu.sv
module vec_elem_alu
    import vec_elem_alu_pkg::*;
#(
    parameter  int ELEM_W = 64,
    parameter  int OPND_W = 32,
    parameter  int MAX_VL = 64,
    localparam int LEN_W  = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_code,
    input  logic              src_scalar,
    input  logic [OPND_W-1:0] scalar_opnd,
    input  logic [LEN_W-1:0]  vec_len,
    input  logic              in_valid,
    input  logic [ELEM_W-1:0] va_elem,
    input  logic [ELEM_W-1:0] vb_elem,
    output logic              busy,
    output logic              out_valid,
    output logic [LEN_W-1:0]  out_index,
    output logic [ELEM_W-1:0] vc_elem,
    output logic              done,
    output logic              ovf_flag
);
    localparam int HI_W = ELEM_W - OPND_W;

    logic              launch, accept;
    logic [LEN_W-1:0]  elem_idx;
    vop_e              op_q;
    logic              src_scalar_q;
    logic [OPND_W-1:0] scalar_q;
    logic [OPND_W-1:0] opnd_a;
    logic [OPND_W-1:0] arith_res, shift_res;
    logic              arith_ovf;
    logic [ELEM_W-1:0] bool_res;
    logic [ELEM_W-1:0] elem_res;

    vec_run_ctrl #(.MAX_VL(MAX_VL), .LEN_W(LEN_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .vec_len  (vec_len),
        .in_valid (in_valid),
        .launch   (launch),
        .accept   (accept),
        .elem_idx (elem_idx),
        .busy     (busy),
        .done     (done)
    );

    // operation and operand source captured once per run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q         <= VOP_ADD;
            src_scalar_q <= 1'b0;
            scalar_q     <= '0;
        end else if (launch) begin
            op_q         <= vop_e'(op_code);
            src_scalar_q <= src_scalar;
            scalar_q     <= scalar_opnd;
        end
    end

    always_comb begin
        opnd_a = src_scalar_q ? scalar_q : va_elem[OPND_W-1:0];
    end

    vec_arith_unit #(.OPND_W(OPND_W)) u_arith (
        .op       (op_q),
        .opnd_a   (opnd_a),
        .opnd_b   (vb_elem[OPND_W-1:0]),
        .result   (arith_res),
        .overflow (arith_ovf)
    );

    vec_bool_unit #(.OPND_W(OPND_W), .ELEM_W(ELEM_W)) u_bool (
        .op     (op_q),
        .opnd_a (opnd_a),
        .vb     (vb_elem),
        .result (bool_res)
    );

    vec_shift_unit #(.OPND_W(OPND_W)) u_shift (
        .shift_right (op_q == VOP_SRL),
        .count_src   (opnd_a),
        .value       (vb_elem[OPND_W-1:0]),
        .result      (shift_res)
    );

    always_comb begin
        if (vop_is_bool(op_q))       elem_res = bool_res;
        else if (vop_is_arith(op_q)) elem_res = {{HI_W{1'b0}}, arith_res};
        else                         elem_res = {{HI_W{1'b0}}, shift_res};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_index <= '0;
            vc_elem   <= '0;
            ovf_flag  <= 1'b0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_index <= elem_idx;
                vc_elem   <= elem_res;
            end
            if (launch)
                ovf_flag <= 1'b0;
            else if (accept && vop_is_arith(op_q) && arith_ovf)
                ovf_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/vec_elem_alu_chk.sv
module vec_elem_alu_chk #(
    parameter int ELEM_W = 64,
    parameter int OPND_W = 32,
    parameter int LEN_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              in_valid,
    input logic [ELEM_W-1:0] vb_elem,
    input logic              busy,
    input logic              out_valid,
    input logic [ELEM_W-1:0] vc_elem,
    input logic              done,
    input logic              ovf_flag,
    input logic [2:0]        op_q
);
    logic op_bool, op_shift;
    always_comb begin
        op_bool  = (op_q == 3'd3) || (op_q == 3'd4) || (op_q == 3'd5);
        op_shift = (op_q == 3'd6) || (op_q == 3'd7);
    end

    assert_upper_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && op_bool |-> vc_elem[ELEM_W-1:OPND_W] == $past(vb_elem[ELEM_W-1:OPND_W]));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !op_bool |-> vc_elem[ELEM_W-1:OPND_W] == '0);

    assert_sticky_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !start |=> ovf_flag);

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && in_valid && !ovf_flag && (op_bool || op_shift) |=> !ovf_flag);

    assert_result_follows_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(busy && in_valid));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind vec_elem_alu vec_elem_alu_chk #(.ELEM_W(ELEM_W), .OPND_W(OPND_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .vb_elem   (vb_elem),
    .busy      (busy),
    .out_valid (out_valid),
    .vc_elem   (vc_elem),
    .done      (done),
    .ovf_flag  (ovf_flag),
    .op_q      (op_q)
);

// File: tb/vec_elem_alu_tb.sv
module vec_elem_alu_tb;
    localparam int MAXV = 64;
    localparam int LW   = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_code = '0;
    logic        src_scalar = 1'b0;
    logic [31:0] scalar_opnd = '0;
    logic [LW-1:0] vec_len = '0;
    logic        in_valid = 1'b0;
    logic [63:0] va_elem = '0, vb_elem = '0;
    logic        busy, out_valid, done, ovf_flag;
    logic [LW-1:0] out_index;
    logic [63:0] vc_elem;

    always #2.5 clk = ~clk;

    vec_elem_alu u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .src_scalar(src_scalar), .scalar_opnd(scalar_opnd), .vec_len(vec_len),
        .in_valid(in_valid), .va_elem(va_elem), .vb_elem(vb_elem),
        .busy(busy), .out_valid(out_valid), .out_index(out_index),
        .vc_elem(vc_elem), .done(done), .ovf_flag(ovf_flag)
    );

    typedef struct {
        logic [63:0] vc;
        int          idx;
        bit          last;
        string       tag;
    } exp_item_t;

    exp_item_t   exp_q[$];
    bit          ovf_q[$];
    string       ovf_tag_q[$];
    int          tests = 0, fails = 0;
    logic [63:0] va_arr[MAXV];
    logic [63:0] vb_arr[MAXV];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // reference model from the requirements: {ovf, result}
    function automatic logic [64:0] ref_op(input logic [2:0] op, input logic [31:0] a,
                                           input logic [63:0] b);
        logic [31:0] r;
        logic        ov;
        longint      p;
        ov = 1'b0;
        case (op)
            3'd0: begin r = a + b[31:0]; ov = (a[31] == b[31]) && (r[31] != a[31]); end
            3'd1: begin r = a - b[31:0]; ov = (a[31] != b[31]) && (r[31] != a[31]); end
            3'd2: begin
                p  = longint'($signed(a)) * longint'($signed(b[31:0]));
                r  = p[31:0];
                ov = (p != longint'($signed(p[31:0])));
            end
            3'd3: return {1'b0, b[63:32], b[31:0] & ~a};
            3'd4: return {1'b0, b[63:32], b[31:0] | a};
            3'd5: return {1'b0, b[63:32], b[31:0] ^ a};
            3'd6: r = b[31:0] << a[4:0];
            default: r = b[31:0] >> a[4:0];
        endcase
        return {ov, 32'h0, r};
    endfunction

    task automatic fill_rand();
        for (int i = 0; i < MAXV; i++) begin
            va_arr[i] = {$urandom, $urandom};
            vb_arr[i] = {$urandom, $urandom};
        end
    endtask

    // driver: pushes expected items, then drives the run
    task automatic run_vec(input logic [2:0] op, input bit use_s, input logic [31:0] scal,
                           input int len, input bit gaps, input bit poke, input string tag);
        int  n;
        bit  ov;
        logic [64:0] r;
        n  = (len > MAXV) ? MAXV : len;
        ov = 1'b0;
        for (int i = 0; i < n; i++) begin
            r  = ref_op(op, use_s ? scal : va_arr[i][31:0], vb_arr[i]);
            ov = ov | r[64];
            exp_q.push_back('{vc: r[63:0], idx: i, last: (i == n - 1), tag: tag});
        end
        ovf_q.push_back(ov);
        ovf_tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b1; op_code = op; src_scalar = use_s; scalar_opnd = scal;
        vec_len = LW'(len);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 2 == 1)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1; va_elem = va_arr[i]; vb_elem = vb_arr[i];
            if (poke && i == 1) begin
                // R9: start while busy with another op and length
                start = 1'b1; op_code = 3'd5; src_scalar = ~use_s; vec_len = LW'(1);
            end
            @(negedge clk);
            start = 1'b0;
        end
        in_valid = 1'b0;
        va_elem  = {$urandom, $urandom};
        vb_elem  = {$urandom, $urandom};
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops and compares
    initial begin
        exp_item_t e;
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected result", vc_elem, 64'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(vc_elem === e.vc, e.tag, "result", vc_elem, e.vc);
                    check(int'(out_index) == e.idx, "R8", "index",
                          64'(out_index), 64'(e.idx));
                    check(done === e.last, "R8", "done with last result",
                          64'(done), 64'(e.last));
                end
            end
            if (rst_n && done) begin
                if (ovf_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected done", 64'(done), 64'h0);
                end else begin
                    automatic bit    xo = ovf_q.pop_front();
                    automatic string tg = ovf_tag_q.pop_front();
                    check(ovf_flag === xo, "R3", {"overflow at done ", tg},
                          64'(ovf_flag), 64'(xo));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0,      "R1", "busy",      64'(busy), 64'h0);
        check(out_valid === 1'b0, "R1", "out_valid", 64'(out_valid), 64'h0);
        check(done === 1'b0,      "R1", "done",      64'(done), 64'h0);
        check(ovf_flag === 1'b0,  "R1", "ovf_flag",  64'(ovf_flag), 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: add from Va, no overflow, with stalls
        fill_rand();
        for (int i = 0; i < 6; i++) begin
            va_arr[i][31:0] = 32'(i * 1000);
            vb_arr[i][31:0] = 32'(i + 7);
        end
        run_vec(3'd0, 1'b0, 32'h0, 6, 1'b1, 1'b0, "R2");

        // R2/R7: subtract scalar minus Vb, Va upper junk ignored
        fill_rand();
        for (int i = 0; i < 5; i++) vb_arr[i] = {32'hFFFF_FFFF, 32'(i * 3)};
        run_vec(3'd1, 1'b1, 32'd100, 5, 1'b0, 1'b0, "R7");

        // R3: overflow on last element, same cycle as done
        fill_rand();
        for (int i = 0; i < 4; i++) begin
            va_arr[i][31:0] = 32'd5;
            vb_arr[i][31:0] = 32'd9;
        end
        va_arr[3][31:0] = 32'h7FFF_FFFF;
        vb_arr[3][31:0] = 32'h0000_0001;
        run_vec(3'd0, 1'b0, 32'h0, 4, 1'b1, 1'b0, "R3");

        // R5/R10: bit-clear after an overflowing run, flag cleared at launch
        fill_rand();
        run_vec(3'd3, 1'b0, 32'h0, 8, 1'b0, 1'b0, "R5");
        fill_rand();
        run_vec(3'd4, 1'b1, 32'hF0F0_1234, 8, 1'b1, 1'b0, "R5");
        fill_rand();
        run_vec(3'd5, 1'b0, 32'h0, 8, 1'b0, 1'b0, "R10");

        // R4: signed multiply with negatives and overflow
        fill_rand();
        va_arr[0][31:0] = 32'hFFFF_FFFD; vb_arr[0][31:0] = 32'd7;
        va_arr[1][31:0] = 32'hFFFF_FFFF; vb_arr[1][31:0] = 32'hFFFF_FFFF;
        va_arr[2][31:0] = 32'h0001_0000; vb_arr[2][31:0] = 32'h0001_0000;
        va_arr[3][31:0] = 32'h8000_0000; vb_arr[3][31:0] = 32'd1;
        run_vec(3'd2, 1'b0, 32'h0, 4, 1'b0, 1'b0, "R4");
        fill_rand();
        va_arr[0][31:0] = 32'hFFFF_8000; vb_arr[0][31:0] = 32'h0001_0000;
        va_arr[1][31:0] = 32'd12345;     vb_arr[1][31:0] = 32'hFFFF_FF00;
        run_vec(3'd2, 1'b0, 32'h0, 2, 1'b1, 1'b0, "R4");

        // R6: shifts, counts 0, 31, 37 (uses 5), large junk upper count bits
        fill_rand();
        va_arr[0][31:0] = 32'd0;  va_arr[1][31:0] = 32'd31;
        va_arr[2][31:0] = 32'd37; va_arr[3][31:0] = 32'hFFFF_FFE4;
        for (int i = 0; i < 4; i++) vb_arr[i][31:0] = 32'h8000_0001;
        run_vec(3'd6, 1'b0, 32'h0, 4, 1'b0, 1'b0, "R6");
        run_vec(3'd7, 1'b0, 32'h0, 4, 1'b1, 1'b0, "R6");
        run_vec(3'd7, 1'b1, 32'd36, 4, 1'b0, 1'b0, "R6");

        // R8: zero length, then clamped length
        run_vec(3'd0, 1'b0, 32'h0, 0, 1'b0, 1'b0, "R8");
        fill_rand();
        run_vec(3'd0, 1'b0, 32'h0, 100, 1'b0, 1'b0, "R8");

        // R9: start while busy is ignored
        fill_rand();
        run_vec(3'd1, 1'b0, 32'h0, 6, 1'b1, 1'b1, "R9");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R8", "results outstanding", 64'(exp_q.size()), 64'h0);
        check(ovf_q.size() == 0, "R8", "done outstanding", 64'(ovf_q.size()), 64'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule